// File: doc/BRIEF.md
# Data-Processing Second-Operand Decoder

This block takes one 32-bit data-processing instruction word and turns it into a normalized description of the second source operand, plus the register fields and control bits that travel with it. For the immediate form it expands the 8-bit constant into its full 32-bit value inside the decoder. For the register forms it reports the operand register, the shift kind, and either a constant shift amount or the register that holds the amount. The zero-amount constant shifts are rewritten into canonical forms, so the execute stage never has to look for them. The block does not move any data through a shifter, does not read the register file, and decodes no other instruction class.

Instructions arrive on a valid/ready stream, and decoded results leave on a second valid/ready stream. With the default `REG_OUT = 1`, one register slice sits between the two streams and a result appears one cycle after its word is accepted. `in_ready` is high whenever the slice is empty or the consumer is taking the current result. While `out_valid` is high and `out_ready` is low, every output holds its value and no new word is accepted. `out_valid` never drops before the consumer has taken the result.

Operand kind encoding: 0 = rotated immediate, 1 = register with constant shift, 2 = register with register shift. Shift kind encoding: 0 = none, 1 = LSL, 2 = LSR, 3 = ASR, 4 = ROR, 5 = RRX.

Top module: `shifter_operand_decoder`

## Requirements
- R1: When bit 25 is 1, the operand kind is 0, and `out_imm` equals bits [7:0] rotated right by twice the value in bits [11:8]. The shift kind, amount, shift register and operand register are then 0. In the register forms `out_imm` is 0.
- R2: When bits 25 and 4 are both 0, the operand kind is 1, the operand register is bits [3:0], and the shift amount is bits [11:7]. The shift kind comes from bits [6:5]: 00 = LSL (1), 01 = LSR (2), 10 = ASR (3), 11 = ROR (4).
- R3: A constant LSL with amount 0 is reported as shift kind 0 (none) with amount 0.
- R4: A constant ROR with amount 0 is reported as shift kind 5 (RRX) with amount 0. A constant LSR or ASR with amount 0 keeps its own kind.
- R5: When bit 25 is 0 and bit 4 is 1, the operand kind is 2, the shift register index is bits [11:8], the shift kind follows the R2 mapping, the amount is 0, and `out_extra_cycle` is 1. In every other form `out_extra_cycle` is 0 and the shift register index is 0.
- R6: `out_rd` is bits [15:12], `out_rn` is bits [19:16], `out_alu_op` is bits [24:21], and `out_set_flags` is bit 20, except where R7 or R8 overrides them.
- R7: For ALU codes 1000, 1001, 1010 and 1011 (the test and compare group), `out_rd_used` is 0, `out_rd` is 0, and `out_set_flags` is 1 whatever bit 20 holds. For all other codes `out_rd_used` is 1.
- R8: For ALU codes 1101 and 1111 (the move group), `out_rn_used` is 0 and `out_rn` is 0. For all other codes `out_rn_used` is 1.
- R9: `out_branch` is 1 exactly when the destination is used and bits [15:12] equal 15.
- R10: `out_bad_form` is 1 when bit 25 is 0 and bits 4 and 7 are both 1. Such a word is otherwise decoded as the register-shift form.
- R11: A word accepted in one cycle appears on the outputs in the next cycle. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is 0. With `in_valid` low and the result taken, `out_valid` falls.
- R12: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | Operand kind |
| out_shift_kind | output | 3 | Shift kind |
| out_shift_amt | output | 5 | Constant shift amount |
| out_shift_reg | output | 4 | Register holding the shift amount |
| out_rm | output | 4 | Operand register |
| out_imm | output | 32 | Expanded immediate |
| out_extra_cycle | output | 1 | One extra internal cycle needed |
| out_rd | output | 4 | Destination register |
| out_rd_used | output | 1 | Destination is written |
| out_rn | output | 4 | First source register |
| out_rn_used | output | 1 | First source is read |
| out_alu_op | output | 4 | ALU operation code |
| out_set_flags | output | 1 | Flags are updated |
| out_branch | output | 1 | Result writes the program counter |
| out_bad_form | output | 1 | Malformed register-shift encoding |

## Verification
The assertions assume that the consumer keeps to the stream rules and that `in_instr` is a defined word whenever `in_valid` is high. They assume nothing about which bit patterns arrive, because every one of the 32 bits decodes to a defined result. The stimulus drives inputs only between clock edges and holds a word steady while it is stalled. It includes the malformed register-shift pattern and compare codes with bit 20 clear, so the invariants are also exercised on words a compiler would not emit.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int INSTR_W  = 32;
  localparam int REG_IDX_W = 4;
  localparam int ALU_OP_W = 4;
  localparam int SH_AMT_W = 5;
  localparam int IMM8_W   = 8;
  localparam int ROT_W    = 4;

  typedef enum logic [1:0] {
    OPK_IMM    = 2'd0,
    OPK_REG_CS = 2'd1,
    OPK_REG_RS = 2'd2
  } opnd_kind_e;

  typedef enum logic [2:0] {
    SHK_NONE = 3'd0,
    SHK_LSL  = 3'd1,
    SHK_LSR  = 3'd2,
    SHK_ASR  = 3'd3,
    SHK_ROR  = 3'd4,
    SHK_RRX  = 3'd5
  } shift_kind_e;

  typedef struct packed {
    opnd_kind_e            kind;
    shift_kind_e           shk;
    logic [SH_AMT_W-1:0]   amt;
    logic [REG_IDX_W-1:0]  sreg;
    logic [REG_IDX_W-1:0]  rm;
    logic [INSTR_W-1:0]    imm;
    logic                  extra;
    logic [REG_IDX_W-1:0]  rd;
    logic                  rd_used;
    logic [REG_IDX_W-1:0]  rn;
    logic                  rn_used;
    logic [ALU_OP_W-1:0]   alu_op;
    logic                  set_flags;
    logic                  branch;
    logic                  bad;
  } opdec_res_t;

endpackage

// File: rtl/opdec_rot_imm.sv
module opdec_rot_imm #(
  parameter int OUT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [BYTE_W-1:0] imm8,
  input  logic [ROT_W-1:0]  rot,
  output logic [OUT_W-1:0]  value
);
  localparam int AMT_W = ROT_W + 1;

  logic [OUT_W-1:0]   base;
  logic [2*OUT_W-1:0] doubled;
  logic [2*OUT_W-1:0] shifted;
  logic [AMT_W-1:0]   amount;

  always_comb begin
    base    = '0;
    base[BYTE_W-1:0] = imm8;
    doubled = {base, base};
    amount  = {rot, 1'b0};
    shifted = doubled >> amount;
    value   = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/opdec_shift_field.sv
module opdec_shift_field
  import opdec_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr,
  output opnd_kind_e           kind,
  output shift_kind_e          shk,
  output logic [SH_AMT_W-1:0]  amt,
  output logic [REG_IDX_W-1:0] sreg,
  output logic [REG_IDX_W-1:0] rm,
  output logic                 extra,
  output logic                 bad
);
  logic        imm_form;
  logic        reg_shift;
  logic [1:0]  sh_code;
  logic [SH_AMT_W-1:0] amt_field;
  shift_kind_e raw_kind;

  assign imm_form  = instr[25];
  assign reg_shift = !imm_form && instr[4];
  assign sh_code   = instr[6:5];
  assign amt_field = instr[11:7];

  always_comb begin
    unique case (sh_code)
      2'b00:   raw_kind = SHK_LSL;
      2'b01:   raw_kind = SHK_LSR;
      2'b10:   raw_kind = SHK_ASR;
      default: raw_kind = SHK_ROR;
    endcase
  end

  always_comb begin
    kind  = OPK_IMM;
    shk   = SHK_NONE;
    amt   = '0;
    sreg  = '0;
    rm    = '0;
    extra = 1'b0;
    if (imm_form) begin
      kind = OPK_IMM;
    end else if (reg_shift) begin
      kind  = OPK_REG_RS;
      shk   = raw_kind;
      sreg  = instr[11:8];
      rm    = instr[3:0];
      extra = 1'b1;
    end else begin
      kind = OPK_REG_CS;
      rm   = instr[3:0];
      amt  = amt_field;
      if (amt_field == '0 && raw_kind == SHK_LSL)
        shk = SHK_NONE;
      else if (amt_field == '0 && raw_kind == SHK_ROR)
        shk = SHK_RRX;
      else
        shk = raw_kind;
    end
  end

  assign bad = reg_shift && instr[7];
endmodule

// File: rtl/opdec_op_class.sv
module opdec_op_class
  import opdec_pkg::*;
#(
  parameter int PC_INDEX = 15
) (
  input  logic [ALU_OP_W-1:0]  alu_op,
  input  logic                 s_bit,
  input  logic [REG_IDX_W-1:0] rd_field,
  input  logic [REG_IDX_W-1:0] rn_field,
  output logic [REG_IDX_W-1:0] rd,
  output logic                 rd_used,
  output logic [REG_IDX_W-1:0] rn,
  output logic                 rn_used,
  output logic                 set_flags,
  output logic                 branch
);
  localparam logic [REG_IDX_W-1:0] PC_IDX = REG_IDX_W'(PC_INDEX);

  logic test_group;
  logic move_group;

  assign test_group = (alu_op[3:2] == 2'b10);
  assign move_group = (alu_op == 4'b1101) || (alu_op == 4'b1111);

  always_comb begin
    rd_used   = !test_group;
    rd        = test_group ? '0 : rd_field;
    rn_used   = !move_group;
    rn        = move_group ? '0 : rn_field;
    set_flags = s_bit || test_group;
    branch    = !test_group && (rd_field == PC_IDX);
  end
endmodule

// File: rtl/opdec_out_stage.sv
module opdec_out_stage #(
  parameter int PAYLOAD_W = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAYLOAD_W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic                 vld_q;
      logic [PAYLOAD_W-1:0] data_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = data_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_ready && in_valid) data_q <= in_data;
      end

      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
      p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/shifter_operand_decoder.sv
module shifter_operand_decoder
  import opdec_pkg::*;
#(
  parameter bit REG_OUT  = 1'b1,
  parameter int PC_INDEX = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_instr,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_kind,
  output logic [2:0]  out_shift_kind,
  output logic [4:0]  out_shift_amt,
  output logic [3:0]  out_shift_reg,
  output logic [3:0]  out_rm,
  output logic [31:0] out_imm,
  output logic        out_extra_cycle,
  output logic [3:0]  out_rd,
  output logic        out_rd_used,
  output logic [3:0]  out_rn,
  output logic        out_rn_used,
  output logic [3:0]  out_alu_op,
  output logic        out_set_flags,
  output logic        out_branch,
  output logic        out_bad_form
);
  localparam int RES_W = $bits(opdec_res_t);

  opdec_res_t res_d;
  opdec_res_t res_q;
  logic [RES_W-1:0] res_q_bits;
  logic [INSTR_W-1:0] rot_value;
  logic unused_cond_bits;

  assign unused_cond_bits = ^in_instr[31:26];

  opdec_rot_imm #(
    .OUT_W (INSTR_W),
    .BYTE_W(IMM8_W),
    .ROT_W (ROT_W)
  ) u_rot (
    .imm8 (in_instr[7:0]),
    .rot  (in_instr[11:8]),
    .value(rot_value)
  );

  opdec_shift_field u_shift (
    .instr(in_instr),
    .kind (res_d.kind),
    .shk  (res_d.shk),
    .amt  (res_d.amt),
    .sreg (res_d.sreg),
    .rm   (res_d.rm),
    .extra(res_d.extra),
    .bad  (res_d.bad)
  );

  opdec_op_class #(.PC_INDEX(PC_INDEX)) u_class (
    .alu_op   (in_instr[24:21]),
    .s_bit    (in_instr[20]),
    .rd_field (in_instr[15:12]),
    .rn_field (in_instr[19:16]),
    .rd       (res_d.rd),
    .rd_used  (res_d.rd_used),
    .rn       (res_d.rn),
    .rn_used  (res_d.rn_used),
    .set_flags(res_d.set_flags),
    .branch   (res_d.branch)
  );

  assign res_d.imm    = in_instr[25] ? rot_value : '0;
  assign res_d.alu_op = in_instr[24:21];

  opdec_out_stage #(
    .PAYLOAD_W(RES_W),
    .REG_OUT  (REG_OUT)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (res_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (res_q_bits)
  );

  assign res_q = opdec_res_t'(res_q_bits);

  assign out_kind        = res_q.kind;
  assign out_shift_kind  = res_q.shk;
  assign out_shift_amt   = res_q.amt;
  assign out_shift_reg   = res_q.sreg;
  assign out_rm          = res_q.rm;
  assign out_imm         = res_q.imm;
  assign out_extra_cycle = res_q.extra;
  assign out_rd          = res_q.rd;
  assign out_rd_used     = res_q.rd_used;
  assign out_rn          = res_q.rn;
  assign out_rn_used     = res_q.rn_used;
  assign out_alu_op      = res_q.alu_op;
  assign out_set_flags   = res_q.set_flags;
  assign out_branch      = res_q.branch;
  assign out_bad_form    = res_q.bad;

  p_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_extra_cycle == (out_kind == 2'd2)));
  p_imm_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd0) |-> (out_imm == 32'd0));
  p_lsl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1 && out_shift_kind == 3'd1) |-> (out_shift_amt != 5'd0));
  p_rrx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_shift_kind == 3'd5) |-> (out_kind == 2'd1 && out_shift_amt == 5'd0));
  p_nodest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rd_used) |-> (out_set_flags && out_rd == 4'd0 && !out_branch));
  p_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_branch) |-> (out_rd_used && out_rd == 4'(PC_INDEX)));
  p_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_form) |-> (out_kind == 2'd2));
endmodule

// File: tb/shifter_operand_decoder_test.sv
`timescale 1ns/1ps
module shifter_operand_decoder_test;

  typedef struct packed {
    logic [31:0] instr;
    logic [1:0]  kind;
    logic [2:0]  shk;
    logic [4:0]  amt;
    logic [3:0]  sreg;
    logic [3:0]  rm;
    logic [31:0] imm;
    logic [3:0]  rd;
    logic [3:0]  rn;
    logic [3:0]  op;
    logic [5:0]  flg; // set_flags, rd_used, rn_used, branch, extra, bad
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'hE28120FF, 2'd0, 3'd0, 5'd0,  4'd0, 4'd0, 32'h000000FF, 4'h2, 4'h1, 4'h4, 6'b011000}, // R1 rot 0
    '{32'hE3B53103, 2'd0, 3'd0, 5'd0,  4'd0, 4'd0, 32'hC0000000, 4'h3, 4'h0, 4'hD, 6'b110000}, // R1 R8
    '{32'hE2446FAB, 2'd0, 3'd0, 5'd0,  4'd0, 4'd0, 32'h000002AC, 4'h6, 4'h4, 4'h2, 6'b011000}, // R1 rot 15
    '{32'hE1878009, 2'd1, 3'd0, 5'd0,  4'd0, 4'h9, 32'h0,        4'h8, 4'h7, 4'hC, 6'b011000}, // R3
    '{32'hE0110282, 2'd1, 3'd1, 5'd5,  4'd0, 4'h2, 32'h0,        4'h0, 4'h1, 4'h0, 6'b111000}, // R2 LSL
    '{32'hE0223023, 2'd1, 3'd2, 5'd0,  4'd0, 4'h3, 32'h0,        4'h3, 4'h2, 4'h1, 6'b011000}, // R4 LSR 0
    '{32'hE09ABFCF, 2'd1, 3'd3, 5'd31, 4'd0, 4'hF, 32'h0,        4'hB, 4'hA, 4'h4, 6'b111000}, // R2 ASR
    '{32'hE0612064, 2'd1, 3'd5, 5'd0,  4'd0, 4'h4, 32'h0,        4'h2, 4'h1, 4'h3, 6'b011000}, // R4 RRX
    '{32'hE0C34465, 2'd1, 3'd4, 5'd8,  4'd0, 4'h5, 32'h0,        4'h4, 4'h3, 4'h6, 6'b011000}, // R2 ROR
    '{32'hE0A89617, 2'd2, 3'd1, 5'd0,  4'd6, 4'h7, 32'h0,        4'h9, 4'h8, 4'h5, 6'b011010}, // R5
    '{32'hE1D12172, 2'd2, 3'd4, 5'd0,  4'd1, 4'h2, 32'h0,        4'h2, 4'h1, 4'hE, 6'b111010}, // R5
    '{32'hE155F334, 2'd2, 3'd2, 5'd0,  4'd3, 4'h4, 32'h0,        4'h0, 4'h5, 4'hA, 6'b101010}, // R7
    '{32'hE3060010, 2'd0, 3'd0, 5'd0,  4'd0, 4'h0, 32'h00000010, 4'h0, 4'h6, 4'h8, 6'b101000}, // R7 S clear
    '{32'hE1A0F00E, 2'd1, 3'd0, 5'd0,  4'd0, 4'hE, 32'h0,        4'hF, 4'h0, 4'hD, 6'b010100}, // R9
    '{32'hE1E01091, 2'd2, 3'd1, 5'd0,  4'd0, 4'h1, 32'h0,        4'h1, 4'h0, 4'hF, 6'b010011}, // R10
    '{32'hE132F003, 2'd1, 3'd0, 5'd0,  4'd0, 4'h3, 32'h0,        4'h0, 4'h2, 4'h9, 6'b101000}, // R7 R9
    '{32'hE29EF004, 2'd0, 3'd0, 5'd0,  4'd0, 4'h0, 32'h00000004, 4'hF, 4'hE, 4'h4, 6'b111100}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [2:0]  out_shift_kind;
  logic [4:0]  out_shift_amt;
  logic [3:0]  out_shift_reg;
  logic [3:0]  out_rm;
  logic [31:0] out_imm;
  logic        out_extra_cycle;
  logic [3:0]  out_rd;
  logic        out_rd_used;
  logic [3:0]  out_rn;
  logic        out_rn_used;
  logic [3:0]  out_alu_op;
  logic        out_set_flags;
  logic        out_branch;
  logic        out_bad_form;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shifter_operand_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_shift_kind(out_shift_kind),
    .out_shift_amt(out_shift_amt), .out_shift_reg(out_shift_reg),
    .out_rm(out_rm), .out_imm(out_imm), .out_extra_cycle(out_extra_cycle),
    .out_rd(out_rd), .out_rd_used(out_rd_used),
    .out_rn(out_rn), .out_rn_used(out_rn_used),
    .out_alu_op(out_alu_op), .out_set_flags(out_set_flags),
    .out_branch(out_branch), .out_bad_form(out_bad_form)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t v);
    check("R1 immediate", 64'(out_imm), 64'(v.imm));
    check("R2 kind/shift/rm", 64'({out_kind, out_shift_kind, out_shift_amt, out_rm}),
          64'({v.kind, v.shk, v.amt, v.rm}));
    check("R5 shift reg/extra", 64'({out_shift_reg, out_extra_cycle}), 64'({v.sreg, v.flg[1]}));
    check("R6 fields", 64'({out_rd, out_rn, out_alu_op, out_set_flags}),
          64'({v.rd, v.rn, v.op, v.flg[5]}));
    check("R7 dest used", 64'(out_rd_used), 64'(v.flg[4]));
    check("R8 src used", 64'(out_rn_used), 64'(v.flg[3]));
    check("R9 branch", 64'(out_branch), 64'(v.flg[2]));
    check("R10 bad form", 64'(out_bad_form), 64'(v.flg[0]));
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12 out_valid in reset", 64'(out_valid), 64'd0);
    check("R12 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // table walk, streaming one word per cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R11 out_valid", 64'(out_valid), 64'd1);
        check_vec(VECS[i-1]);
      end
      in_valid = 1'b1;
      in_instr = VECS[i].instr;
    end
    @(negedge clk);
    check("R11 out_valid", 64'(out_valid), 64'd1);
    check_vec(VECS[NV-1]);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 drain", 64'(out_valid), 64'd0);

    // R3 directed: LSL amount 0 becomes no shift
    in_valid = 1'b1; in_instr = 32'hE1A01002;
    @(negedge clk); in_valid = 1'b0;
    check("R3 lsl0 kind/amt", 64'({out_kind, out_shift_kind, out_shift_amt}), 64'({2'd1, 3'd0, 5'd0}));

    // R4 directed: ROR amount 0 becomes RRX, ASR amount 0 stays ASR
    in_valid = 1'b1; in_instr = 32'hE1A01063;
    @(negedge clk);
    check("R4 ror0 rrx", 64'({out_shift_kind, out_shift_amt}), 64'({3'd5, 5'd0}));
    in_instr = 32'hE1A01043;
    @(negedge clk); in_valid = 1'b0;
    check("R4 asr0 stays", 64'({out_shift_kind, out_shift_amt}), 64'({3'd3, 5'd0}));
    @(negedge clk);

    // R11 back-pressure: hold result while consumer stalls
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = VECS[4].instr;
    @(negedge clk);
    check("R11 loaded", 64'({out_valid, out_shift_amt, out_rm}), 64'({1'b1, 5'd5, 4'h2}));
    check("R11 stall ready", 64'(in_ready), 64'd0);
    in_instr = VECS[6].instr;
    repeat (2) @(negedge clk);
    check("R11 held", 64'({out_valid, out_shift_amt, out_rm}), 64'({1'b1, 5'd5, 4'h2}));
    check("R11 still stalled", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R11 next after release", 64'({out_valid, out_shift_amt, out_rm}), 64'({1'b1, 5'd31, 4'hF}));
    @(negedge clk);
    check("R11 empty", 64'(out_valid), 64'd0);

    // R12 reset while a result is pending
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = VECS[0].instr;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", 64'({out_valid, in_ready}), 64'({1'b0, 1'b1}));
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule